// File: doc/BRIEF.md
# Segmented Carry-Speculating Adder

This block is a purely combinational adder of width `N` whose operands are split into segments of `K` bits. Each segment is a short ripple-carry chain of one-bit full adders. The carry into every segment above the lowest one can come from one of two sources. In approximate mode it is a fast guess taken from the operand bits just below the boundary. In exact mode it comes from the block generate and propagate of the lower segment, chained in lookahead fashion, so the result is a correct sum.

In approximate mode the guess uses only the top bit of the lower segment, so the upper segments need not wait for the full carry chain. The cost is that a carry which should cross a boundary through a run of propagate bits can be lost. An error output compares the produced result with a full-precision sum, so the caller can see when the guess went wrong. Supported shapes are 8/2, 8/4, 16/2, 16/4 and 16/8 (`N`/`K`). Other shapes are rejected at elaboration.

Top module: `spec_carry_adder`

## Requirements
- R1: The low `K` bits of `sum` always equal the low `K` bits of `op_a + op_b`, in both modes.
- R2: With `exact_en` = 1, `{cout, sum}` equals the (N+1)-bit value `op_a + op_b`.
- R3: With `exact_en` = 0, the carry into segment j+1 is `op_a[i] & op_b[i]`, where i = (j+1)*K-1 is the top bit of segment j. Each segment's sum bits are the low K bits of (its A bits + its B bits + that carry).
- R4: With `exact_en` = 0, `cout` is the carry out of the top segment, computed with the carry selected into that segment under R3.
- R5: `err` is 1 exactly when `{cout, sum}` differs from the (N+1)-bit value `op_a + op_b`.
- R6: `err` is 0 whenever `exact_en` = 1.
- R7: In approximate mode, `{cout, sum}` never exceeds the exact (N+1)-bit sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| exact_en | input | 1 | 1 selects the exact lookahead carry, 0 selects the speculated carry |
| sum | output | N | Sum bits |
| cout | output | 1 | Carry out of the top segment |
| err | output | 1 | High when the result differs from the exact sum |

## Verification
The 8-bit, 2-bit-segment shape is swept over every operand pair in both modes. In exact mode this shows that the lookahead selection reproduces a true sum. In approximate mode each result is matched bit for bit against an arithmetic per-segment model, which separates a wrong speculation bit index from a wrong segment width. A second 16/4 instance gets directed patterns. All-ones plus one and long propagate runs across boundaries set off the speculation error, while pure generate at segment tops and disjoint operands do not. Together these tell apart a missed error from a spurious one.

// File: rtl/spec_carry_adder.sv
module spec_carry_adder #(
  parameter int N = 8,
  parameter int K = 2
) (
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic         exact_en,
  output logic [N-1:0] sum,
  output logic         cout,
  output logic         err
);
  localparam int SEGS = N / K;

  if ((N % K) != 0 || !((N == 8 && (K == 2 || K == 4)) ||
                         (N == 16 && (K == 2 || K == 4 || K == 8)))) begin : g_bad_shape
    $error("spec_carry_adder: unsupported N/K shape");
  end

  logic [N:0]      c;
  logic [SEGS-1:0] blk_g, blk_p;
  logic [N:0]      exact_full;

  assign c[0] = 1'b0;

  for (genvar j = 0; j < SEGS; j++) begin : g_seg
    logic [K-1:0] sa, sb;
    assign sa = op_a[j*K +: K];
    assign sb = op_b[j*K +: K];

    always_comb begin
      logic g, p;
      g = 1'b0;
      p = 1'b1;
      for (int k = 0; k < K; k++) begin
        g = (sa[k] & sb[k]) | ((sa[k] ^ sb[k]) & g);
        p = p & (sa[k] ^ sb[k]);
      end
      blk_g[j] = g;
      blk_p[j] = p;
    end

    for (genvar k = 0; k < K; k++) begin : g_bit
      localparam int I = j*K + k;
      assign sum[I] = op_a[I] ^ op_b[I] ^ c[I];
      if (k < K-1 || j == SEGS-1) begin : g_ripple
        assign c[I+1] = (op_a[I] & op_b[I]) | ((op_a[I] ^ op_b[I]) & c[I]);
      end
    end

    if (j < SEGS-1) begin : g_select
      logic spec;
      assign spec = op_a[(j+1)*K-1] & op_b[(j+1)*K-1];
      assign c[(j+1)*K] = exact_en ? (blk_g[j] | (blk_p[j] & c[j*K])) : spec;
    end
  end

  assign cout       = c[N];
  assign exact_full = {1'b0, op_a} + {1'b0, op_b};
  assign err        = ({cout, sum} != exact_full);
endmodule

module spec_carry_adder_chk #(
  parameter int N = 8,
  parameter int K = 2
) (
  input logic [N-1:0] op_a,
  input logic [N-1:0] op_b,
  input logic         exact_en,
  input logic [N-1:0] sum,
  input logic         cout,
  input logic         err
);
  logic [N:0] ref_sum;
  assign ref_sum = {1'b0, op_a} + {1'b0, op_b};

  always_comb begin
    assert_low_segment_R1: assert (sum[K-1:0] == ref_sum[K-1:0]);
    if (exact_en) begin
      assert_exact_sum_R2: assert ({cout, sum} == ref_sum);
      assert_no_err_exact_R6: assert (!err);
    end else begin
      assert_never_above_R7: assert ({cout, sum} <= ref_sum);
    end
  end
endmodule

bind spec_carry_adder spec_carry_adder_chk #(.N(N), .K(K)) chk_i (
  .op_a(op_a), .op_b(op_b), .exact_en(exact_en),
  .sum(sum), .cout(cout), .err(err)
);

// File: tb/spec_carry_adder_tb.sv
module spec_carry_adder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8,  KA = 2;
  localparam int NB = 16, KB = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [NA-1:0] a8, b8, s8;
  logic          x8, c8, e8;
  logic [NB-1:0] a16, b16, s16;
  logic          x16, c16, e16;

  spec_carry_adder #(.N(NA), .K(KA)) dut_i (
    .op_a(a8), .op_b(b8), .exact_en(x8), .sum(s8), .cout(c8), .err(e8));
  spec_carry_adder #(.N(NB), .K(KB)) dut_w (
    .op_a(a16), .op_b(b16), .exact_en(x16), .sum(s16), .cout(c16), .err(e16));

  function automatic logic [NB:0] model(input logic [NB-1:0] a, input logic [NB-1:0] b,
                                        input logic ex, input int n, input int k);
    logic [NB:0] r;
    logic cin;
    int v;
    if (ex) return ({1'b0, a} + {1'b0, b}) & ((17'd1 << (n+1)) - 1);
    r = '0;
    cin = 1'b0;
    for (int j = 0; j < n/k; j++) begin
      if (j > 0) cin = a[j*k-1] & b[j*k-1];
      v = int'((a >> (j*k)) & ((1 << k) - 1)) + int'((b >> (j*k)) & ((1 << k) - 1)) + int'(cin);
      r = r | (NB+1)'((v & ((1 << k) - 1)) << (j*k));
      if (j == n/k - 1) r[n] = v[k];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [NB:0] got, input logic [NB:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run16(input logic [NB-1:0] a, input logic [NB-1:0] b, input logic ex,
                       input logic exp_err, input string req);
    logic [NB:0] m;
    @(negedge clk);
    a16 = a; b16 = b; x16 = ex;
    @(posedge clk);
    m = model(a, b, ex, NB, KB);
    check({req, " R3 R4 sum"}, {c16, s16}, m);
    check({req, " R5 err"}, {16'd0, e16}, {16'd0, exp_err});
  endtask

  initial begin
    a8 = '0; b8 = '0; x8 = 1'b0;
    a16 = '0; b16 = '0; x16 = 1'b0;
    @(posedge clk);
    check("R1 idle zero", {8'd0, c8, s8}, '0);
    check("R5 idle err", {16'd0, e8}, '0);

    for (int ex = 0; ex < 2; ex++) begin
      for (int v = 0; v < 65536; v++) begin
        logic [NB:0] m, full;
        @(negedge clk);
        a8 = v[7:0]; b8 = v[15:8]; x8 = ex[0];
        @(posedge clk);
        m = model({8'd0, v[7:0]}, {8'd0, v[15:8]}, ex[0], NA, KA);
        full = 17'(v[7:0]) + 17'(v[15:8]);
        if (ex == 1) check("R2 exact sweep", {8'd0, c8, s8}, full);
        else         check("R3 R4 approx sweep", {8'd0, c8, s8}, m);
        check("R1 low segment", 17'(s8[KA-1:0]), 17'(full[KA-1:0]));
        check(ex == 1 ? "R6 err exact" : "R5 err approx", 17'(e8), 17'(m != full));
        if (ex == 0 && m > full) check("R7 not above", m, full);
      end
    end

    run16(16'hFFFF, 16'h0001, 1'b0, 1'b1, "carry chain lost");
    run16(16'hFFFF, 16'h0001, 1'b1, 1'b0, "R2 R6 carry chain exact");
    run16(16'h0888, 16'h0888, 1'b0, 1'b0, "generate at segment tops");
    run16(16'h5555, 16'hAAAA, 1'b0, 1'b0, "disjoint bits");
    run16(16'h00F0, 16'h0010, 1'b0, 1'b1, "propagate run");
    run16(16'h8000, 16'h8000, 1'b0, 1'b0, "top carry out");
    run16(16'h1234, 16'hFEDC, 1'b1, 1'b0, "R2 R6 mixed exact");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule